// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for one Ethernet PHY as seen through a MAC's management frame register. Software writes a 32-bit frame word. One bit of the word picks a read or a write. A 9-bit field names the target, and the low 16 bits carry write data. The block applies the write to its PHY register set, or it looks up the addressed register. On a read, it returns the value in the low half of the frame register. Every frame produces a one-cycle completion pulse, which the surrounding controller ORs into its event register.

The block does not model serial clocking, a real negotiation partner or vendor-specific registers. A control write completes auto-negotiation at once. A synchronous link input is watched for edges. Each edge updates the link and negotiation-done status bits and sets sticky bits in an interrupt-source register. Reading that register returns its contents and then clears it.

Top module: `mgmt_phy_model`

## Requirements
- R1: After reset, register 0 reads 0x3000, register 1 reads 0x7809 while the link input is low, register 4 reads 0x01E1, and registers 29 and 30 read 0x0000. The frame register is 0 and the completion pulse is low.
- R2: In a frame word, bit 28 set means a write and bit 28 clear means a read. Bits 26:23 hold the PHY address, bits 22:18 the register number and bits 15:0 the write data. A read frame never changes a register, whatever its data bits hold.
- R3: The completion output is high for exactly the one cycle after each cycle in which a frame is written, for reads and writes alike, and is low at all other times.
- R4: After a write frame, the frame register holds the word exactly as written. After a read frame, bits 31:16 keep the written word and bits 15:0 hold the read value, which is taken before any update made in that same cycle.
- R5: A write to register 0 stores the data ANDed with 0x7980, and it also sets status bit 5 (negotiation done) in register 1.
- R6: A write to register 4 stores the data ANDed with 0x2D7F, with bit 7 forced to 1.
- R7: A write to register 30 keeps only data bits 7:0; bits 15:8 read as 0.
- R8: A rising edge on the link input sets status bits 5 and 2 and interrupt-source bits 7 and 6. A falling edge clears status bits 5 and 2 and sets interrupt-source bit 4. A constant level changes nothing.
- R9: Reading register 29 returns the latched bits and clears them. A link edge in the same cycle as that read still leaves its bits set.
- R10: Register 5 reads a fixed partner-ability value (default 0x45E1) and register 6 a fixed expansion value (default 0x0001). All other register numbers read 0. Writes to registers 1, 5, 6, 29 and any unlisted number are ignored.
- R11: Only the configured PHY address (default 0) responds. A read at any other address returns 0xFFFF, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wr | input | 1 | One-cycle strobe: a frame word is written this cycle |
| frame_wdata | input | 32 | Frame word being written |
| link_up | input | 1 | Link level, already synchronous to clk |
| frame_q | output | 32 | Current frame register contents |
| mgmt_done | output | 1 | One-cycle management completion event |

## Verification
The assertions assume that `link_up` is already synchronous to `clk` and that `frame_wdata` is meaningful only while `frame_wr` is high. The link checks relate an edge seen at the port to the status and source bits one cycle later, so the link input must hold steady for at least one cycle around each edge. The stimulus changes the link level and the frame strobe only on falling clock edges. It leaves idle cycles between frames and holds each link level for several cycles. In one deliberate case, a link edge and a read of the interrupt-source register arrive in the same cycle, to exercise the order of clear and set.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

    localparam int REG_W     = 16;
    localparam int FRAME_W   = 32;
    localparam int RADDR_W   = 5;
    localparam int PADDR_W   = 4;
    localparam int OP_BIT    = 28;
    localparam int RADDR_LSB = 18;
    localparam int PADDR_LSB = RADDR_LSB + RADDR_W;

    localparam logic [RADDR_W-1:0] RA_CTRL = 5'd0;
    localparam logic [RADDR_W-1:0] RA_STAT = 5'd1;
    localparam logic [RADDR_W-1:0] RA_ADV  = 5'd4;
    localparam logic [RADDR_W-1:0] RA_LPA  = 5'd5;
    localparam logic [RADDR_W-1:0] RA_EXP  = 5'd6;
    localparam logic [RADDR_W-1:0] RA_ISRC = 5'd29;
    localparam logic [RADDR_W-1:0] RA_IMSK = 5'd30;

    localparam logic [REG_W-1:0] CTRL_RST  = 16'h3000;
    localparam logic [REG_W-1:0] STAT_RST  = 16'h7809;
    localparam logic [REG_W-1:0] ADV_RST   = 16'h01E1;
    localparam logic [REG_W-1:0] CTRL_MASK = 16'h7980;
    localparam logic [REG_W-1:0] ADV_MASK  = 16'h2D7F;
    localparam logic [REG_W-1:0] ADV_FORCE = 16'h0080;
    localparam logic [REG_W-1:0] IMSK_MASK = 16'h00FF;

    localparam logic [REG_W-1:0] STAT_ANDONE = 16'h0020;
    localparam logic [REG_W-1:0] STAT_LINK   = 16'h0024;
    localparam logic [REG_W-1:0] SRC_ENERGY  = 16'h0080;
    localparam logic [REG_W-1:0] SRC_ANDONE  = 16'h0040;
    localparam logic [REG_W-1:0] SRC_DOWN    = 16'h0010;
    localparam logic [REG_W-1:0] NO_PHY      = 16'hFFFF;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic               hit;
        logic [RADDR_W-1:0] ra;
        logic [REG_W-1:0]   data;
    } mgmt_op_t;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] adv;
        logic [REG_W-1:0] isrc;
        logic [REG_W-1:0] imsk;
    } phy_regs_t;

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
    import mgmt_phy_pkg::*;
#(
    parameter logic [PADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    output mgmt_op_t           op
);

    always_comb begin
        op.wr   = frame_wr &  frame_wdata[OP_BIT];
        op.rd   = frame_wr & ~frame_wdata[OP_BIT];
        op.hit  = (frame_wdata[PADDR_LSB +: PADDR_W] == PHY_ADDR);
        op.ra   = frame_wdata[RADDR_LSB +: RADDR_W];
        op.data = frame_wdata[REG_W-1:0];
    end

endmodule

// File: rtl/mgmt_link_watch.sv
module mgmt_link_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic link_rise,
    output logic link_fall
);

    logic level_d, level_q;

    always_comb begin
        level_d   = link_up;
        link_rise = link_up & ~level_q;
        link_fall = ~link_up & level_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
    import mgmt_phy_pkg::*;
#(
    parameter logic [REG_W-1:0] LP_ABILITY   = 16'h45E1,
    parameter logic [REG_W-1:0] AN_EXPANSION = 16'h0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mgmt_op_t         op,
    input  logic             link_rise,
    input  logic             link_fall,
    output logic [REG_W-1:0] rd_data,
    output phy_regs_t        regs
);

    phy_regs_t r_d, r_q;

    // read path: value before this cycle's update
    always_comb begin
        rd_data = '0;
        if (!op.hit) begin
            rd_data = NO_PHY;
        end else begin
            case (op.ra)
                RA_CTRL: rd_data = r_q.ctrl;
                RA_STAT: rd_data = r_q.stat;
                RA_ADV:  rd_data = r_q.adv;
                RA_LPA:  rd_data = LP_ABILITY;
                RA_EXP:  rd_data = AN_EXPANSION;
                RA_ISRC: rd_data = r_q.isrc;
                RA_IMSK: rd_data = r_q.imsk;
                default: rd_data = '0;
            endcase
        end
    end

    // next state: software write, read-clear, then link events last
    always_comb begin
        r_d = r_q;
        if (op.wr && op.hit) begin
            case (op.ra)
                RA_CTRL: begin
                    r_d.ctrl = op.data & CTRL_MASK;
                    r_d.stat = r_q.stat | STAT_ANDONE;
                end
                RA_ADV:  r_d.adv  = (op.data & ADV_MASK) | ADV_FORCE;
                RA_IMSK: r_d.imsk = op.data & IMSK_MASK;
                default: ;
            endcase
        end
        if (op.rd && op.hit && (op.ra == RA_ISRC)) begin
            r_d.isrc = '0;
        end
        if (link_rise) begin
            r_d.stat = r_d.stat | STAT_LINK;
            r_d.isrc = r_d.isrc | SRC_ENERGY | SRC_ANDONE;
        end
        if (link_fall) begin
            r_d.stat = r_d.stat & ~STAT_LINK;
            r_d.isrc = r_d.isrc | SRC_DOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= CTRL_RST;
            r_q.stat <= STAT_RST;
            r_q.adv  <= ADV_RST;
            r_q.isrc <= '0;
            r_q.imsk <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;

endmodule

// File: rtl/mgmt_phy_model.sv
module mgmt_phy_model
    import mgmt_phy_pkg::*;
#(
    parameter logic [PADDR_W-1:0] PHY_ADDR     = '0,
    parameter logic [REG_W-1:0]   LP_ABILITY   = 16'h45E1,
    parameter logic [REG_W-1:0]   AN_EXPANSION = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_wr,
    input  logic [31:0] frame_wdata,
    input  logic        link_up,
    output logic [31:0] frame_q,
    output logic        mgmt_done
);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               done;
    } top_state_t;

    mgmt_op_t         op;
    logic             link_rise, link_fall;
    logic [REG_W-1:0] rd_data;
    phy_regs_t        phy_regs;
    top_state_t       st_d, st_q;

    mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .op          (op)
    );

    mgmt_link_watch u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .link_rise (link_rise),
        .link_fall (link_fall)
    );

    mgmt_phy_regs #(
        .LP_ABILITY   (LP_ABILITY),
        .AN_EXPANSION (AN_EXPANSION)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .link_rise (link_rise),
        .link_fall (link_fall),
        .rd_data   (rd_data),
        .regs      (phy_regs)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = frame_wr;
        if (op.wr) begin
            st_d.frame = frame_wdata;
        end else if (op.rd) begin
            st_d.frame = {frame_wdata[FRAME_W-1:REG_W], rd_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_q   = st_q.frame;
    assign mgmt_done = st_q.done;

endmodule

// File: rtl/mgmt_phy_checker.sv
module mgmt_phy_checker
    import mgmt_phy_pkg::*;
#(
    parameter logic [PADDR_W-1:0] PHY_ADDR = '0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_wr,
    input logic [31:0] frame_wdata,
    input logic        link_up,
    input logic [31:0] frame_q,
    input logic        mgmt_done,
    input phy_regs_t   regs
);

    // R3
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> mgmt_done);

    // R3
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wr |=> !mgmt_done);

    // R4
    frame_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> frame_q[31:16] == $past(frame_wdata[31:16]));

    // R4
    frame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && frame_wdata[OP_BIT]) |=> frame_q == $past(frame_wdata));

    // R11
    foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && !frame_wdata[OP_BIT]
         && frame_wdata[PADDR_LSB +: PADDR_W] != PHY_ADDR)
        |=> frame_q[15:0] == NO_PHY);

    // R8
    link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |=> (regs.stat[5] && regs.stat[2]
                            && regs.isrc[7] && regs.isrc[6]));

    // R8
    link_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up) |=> (!regs.stat[5] && !regs.stat[2] && regs.isrc[4]));

    // R5
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.ctrl & ~CTRL_MASK) == '0);

    // R6
    adv_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs.adv[7]);

    // R7
    imsk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs.imsk[15:8] == '0);

endmodule

bind mgmt_phy_model mgmt_phy_checker #(.PHY_ADDR(PHY_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_wr    (frame_wr),
    .frame_wdata (frame_wdata),
    .link_up     (link_up),
    .frame_q     (frame_q),
    .mgmt_done   (mgmt_done),
    .regs        (phy_regs)
);

// File: tb/mgmt_phy_model_test.sv
module mgmt_phy_model_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic        link_up = 1'b0;
    logic [31:0] frame_q;
    logic        mgmt_done;

    int checks = 0;
    int errors = 0;
    int issued = 0;
    int pulses = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    mgmt_phy_model uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .link_up     (link_up),
        .frame_q     (frame_q),
        .mgmt_done   (mgmt_done)
    );

    function automatic logic [31:0] mk(input bit wr, input logic [3:0] phy,
                                        input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, 1'b1, wr, 1'b0, phy, ra, 2'b10, d};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pop expected frame value on each completion pulse
    always @(negedge clk) begin
        if (rst_n && mgmt_done && !finished) begin
            pulses++;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3: actual unexpected completion expected none");
            end else begin
                check(tag_q.pop_front(), frame_q, exp_q.pop_front());
            end
        end
    end

    // driver: called at a falling edge
    task automatic issue(input logic [31:0] w, input logic [31:0] exp, input string tag);
        frame_wr    = 1'b1;
        frame_wdata = w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issued++;
        @(negedge clk);
        frame_wr    = 1'b0;
        frame_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R3 done low in gap", {31'b0, mgmt_done}, 32'h0);
    endtask

    task automatic rd(input logic [3:0] phy, input logic [4:0] ra,
                      input logic [15:0] exp, input string tag);
        logic [31:0] w;
        w = mk(1'b0, phy, ra, 16'h5A5A);
        issue(w, {w[31:16], exp}, tag);
    endtask

    task automatic wr(input logic [3:0] phy, input logic [4:0] ra,
                      input logic [15:0] d, input string tag);
        logic [31:0] w;
        w = mk(1'b1, phy, ra, d);
        issue(w, w, tag);
    endtask

    task automatic set_link(input logic v);
        link_up = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 frame reset", frame_q, 32'h0);
        check("R1 done reset", {31'b0, mgmt_done}, 32'h0);

        rd(4'd0, 5'd0,  16'h3000, "R1 ctrl reset");
        rd(4'd0, 5'd1,  16'h7809, "R1 status reset");
        rd(4'd0, 5'd4,  16'h01E1, "R1 adv reset");
        rd(4'd0, 5'd29, 16'h0000, "R1 src reset");
        rd(4'd0, 5'd30, 16'h0000, "R1 mask reset");

        wr(4'd0, 5'd0, 16'hFFFF, "R4 write frame kept");
        rd(4'd0, 5'd0, 16'h7980, "R5 ctrl mask");
        rd(4'd0, 5'd1, 16'h7829, "R5 status andone");
        rd(4'd0, 5'd0, 16'h7980, "R2 read op leaves ctrl");

        wr(4'd0, 5'd4, 16'hFFFF, "R4 write frame kept");
        rd(4'd0, 5'd4, 16'h2DFF, "R6 adv all ones");
        wr(4'd0, 5'd4, 16'h0000, "R4 write frame kept");
        rd(4'd0, 5'd4, 16'h0080, "R6 adv forced bit");

        wr(4'd0, 5'd30, 16'hABCD, "R4 write frame kept");
        rd(4'd0, 5'd30, 16'h00CD, "R7 mask low byte");

        set_link(1'b1);
        rd(4'd0, 5'd1,  16'h782D, "R8 status link up");
        rd(4'd0, 5'd29, 16'h00C0, "R8 src link up");
        rd(4'd0, 5'd29, 16'h0000, "R9 src cleared");
        set_link(1'b1);
        rd(4'd0, 5'd29, 16'h0000, "R8 steady level no event");

        set_link(1'b0);
        rd(4'd0, 5'd1,  16'h7809, "R8 status link down");
        rd(4'd0, 5'd29, 16'h0010, "R8 src link down");
        rd(4'd0, 5'd29, 16'h0000, "R9 src cleared");

        // link edge in the same cycle as the clearing read
        link_up = 1'b1;
        rd(4'd0, 5'd29, 16'h0000, "R9 read during edge");
        rd(4'd0, 5'd29, 16'h00C0, "R9 edge survives clear");

        rd(4'd0, 5'd5,  16'h45E1, "R10 partner ability");
        rd(4'd0, 5'd6,  16'h0001, "R10 expansion");
        rd(4'd0, 5'd2,  16'h0000, "R10 unlisted reg 2");
        rd(4'd0, 5'd31, 16'h0000, "R10 unlisted reg 31");
        wr(4'd0, 5'd1,  16'h0000, "R4 write frame kept");
        rd(4'd0, 5'd1,  16'h782D, "R10 status write ignored");
        link_up = 1'b0;
        repeat (2) @(negedge clk);
        wr(4'd0, 5'd29, 16'hFFFF, "R4 write frame kept");
        rd(4'd0, 5'd29, 16'h0010, "R10 src write ignored");

        rd(4'd3, 5'd0,  16'hFFFF, "R11 foreign read");
        wr(4'd3, 5'd0,  16'h0000, "R4 write frame kept");
        wr(4'd8, 5'd30, 16'h0000, "R4 write frame kept");
        rd(4'd0, 5'd0,  16'h7980, "R11 foreign write ignored");
        rd(4'd0, 5'd30, 16'h00CD, "R11 foreign mask write ignored");

        repeat (3) @(negedge clk);
        check("R3 pulse count", pulses, issued);
        check("R3 queue drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule